// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps three 256-bit vectors for a processor's interrupt front end: pending requests, vectors in service and the trigger mode of each vector. An interrupt source raises a request by presenting a vector number and a level/edge flag. The controller finds the most urgent pending vector and decides whether to interrupt the processor. That decision weighs the vector against a processor priority, which is derived from the software task priority and the most urgent vector already in service.

The processor takes an interrupt by pulsing an acknowledge strobe. In that same cycle it reads the vector the controller hands over. That vector is either the winning request, which then moves into service, or a programmable spurious vector when the request does not clear the task priority. Finishing a handler is signalled with an end-of-interrupt strobe, which retires the most urgent in-service vector. Software sees the vectors as eight 32-bit words each. The task priority has an 8-bit port and a 4-bit class-only port. A 9-bit spurious register carries the software enable in its top bit.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The selected request is the highest-numbered set bit of the pending vector. A lower-numbered pending vector is never acknowledged while a higher one is pending.
- R2: A set request with `set_valid_i` high sets pending bit `set_vec_i` on the next edge. It also writes `set_level_i` into trigger bit `set_vec_i` (1 = level, 0 = edge).
- R3: `irq_o` is high only when spurious register bit 8 (the enable) is 1 and at least one request is pending.
- R4: `irq_o` is low when the processor priority is nonzero and bits [7:4] of the selected request are not greater than bits [7:4] of the processor priority.
- R5: `ppr_o` equals the task priority when task priority bits [7:4] are at least the class (bits [7:4]) of the highest in-service vector, or when nothing is in service. Otherwise `ppr_o` equals that in-service class in bits [7:4] with bits [3:0] zero.
- R6: An acknowledge is accepted when the block is enabled, a request is pending, and either the task priority is zero or the selected vector exceeds it. On acceptance `ack_vec_o` shows the selected vector, and on the edge that bit leaves the pending vector and enters the in-service vector.
- R7: An acknowledge that is not accepted (below or equal to a nonzero task priority, nothing pending, or disabled) shows spurious register bits [7:0] on `ack_vec_o` and leaves the pending vector unchanged.
- R8: An end-of-interrupt strobe clears the highest set in-service bit. With nothing in service it changes nothing.
- R9: The spurious register stores all 9 written bits and resets to 0x0FF, so the block starts disabled.
- R10: A 4-bit class write stores the value in task priority bits [7:4] and zeroes bits [3:0]. `tpr_nib_o` returns bits [7:4]. A full 8-bit write in the same cycle takes precedence.
- R11: In one cycle, the end-of-interrupt clear is applied first, then the acknowledge transfer, then the set request. A set and an accepted acknowledge of the same vector leave it both in service and pending.
- R12: Reset clears the pending, in-service and trigger vectors and the task priority.
- R13: `rd_data_o` returns bits [32*w+31:32*w] of the vector chosen by `rd_sel_i` (0 pending, 1 in service, 2 trigger, 3 returns zero), where w is `rd_word_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_valid_i | input | 1 | Raise a request this cycle |
| set_vec_i | input | 8 | Vector number of the request |
| set_level_i | input | 1 | Trigger mode of the request, 1 = level |
| ack_i | input | 1 | Processor acknowledge strobe |
| ack_vec_o | output | 8 | Vector an acknowledge in this cycle returns |
| eoi_i | input | 1 | End-of-interrupt strobe |
| tpr_we_i | input | 1 | Full task priority write |
| tpr_wdata_i | input | 8 | Full task priority value |
| tpr_nib_we_i | input | 1 | Class-only task priority write |
| tpr_nib_i | input | 4 | Class value for task priority bits [7:4] |
| tpr_o | output | 8 | Task priority |
| tpr_nib_o | output | 4 | Task priority bits [7:4] |
| svr_we_i | input | 1 | Spurious register write |
| svr_wdata_i | input | 9 | Spurious register value, bit 8 = enable |
| svr_o | output | 9 | Spurious register |
| ppr_o | output | 8 | Processor priority |
| irq_o | output | 1 | Interrupt request to the processor |
| rd_sel_i | input | 2 | Readback vector select |
| rd_word_i | input | 3 | Readback word index |
| rd_data_o | output | 32 | Readback word |

## Verification
A corrupted pending or in-service bit is visible in the same cycle on `rd_data_o` for the affected word. It also shows at once on `ppr_o` and `irq_o` when it changes the winning vector or the in-service class. A wrong selection or transfer shows on `ack_vec_o` at the first acknowledge, and again one cycle later in the readback of the source and destination bits. Ordering faults among end-of-interrupt, acknowledge and set in one cycle surface on the next readback of the shared vector. For that reason the reference model compares every output and a rotating readback word on every clock.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [1:0] {
    RD_PEND  = 2'd0,
    RD_SERV  = 2'd1,
    RD_TRIG  = 2'd2,
    RD_ZERO  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/vpc_hi_find.sv
module vpc_hi_find #(
  parameter int N = 256,
  parameter int W = 32
) (
  input  logic [N-1:0]         vec_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int NW = N / W;
  localparam int WB = $clog2(W);
  localparam int IB = $clog2(N);

  logic [NW-1:0]         word_any;
  logic [NW-1:0][WB-1:0] word_idx;

  // first level: per-word encoders
  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [WB-1:0] idx_l;
    always_comb begin
      idx_l = '0;
      for (int b = 0; b < W; b++)
        if (vec_i[g*W+b]) idx_l = WB'(b);
    end
    assign word_any[g] = |vec_i[g*W +: W];
    assign word_idx[g] = idx_l;
  end

  // second level: highest non-empty word wins
  always_comb begin
    any_o = |word_any;
    idx_o = '0;
    for (int w = 0; w < NW; w++)
      if (word_any[w]) idx_o = IB'(w * W) | IB'(word_idx[w]);
  end
endmodule

// File: rtl/vpc_prio_eval.sv
module vpc_prio_eval #(
  parameter int VEC_W = 8
) (
  input  logic             sw_en_i,
  input  logic             irr_any_i,
  input  logic [VEC_W-1:0] irr_hi_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_hi_i,
  input  logic [VEC_W-1:0] tpr_i,
  output logic [VEC_W-1:0] ppr_o,
  output logic             irq_o,
  output logic             ack_ok_o
);
  import vpc_pkg::*;
  localparam int LO_W = VEC_W - CLS_W;

  logic [CLS_W-1:0] isr_cls, tpr_cls, irr_cls, ppr_cls;

  always_comb begin
    isr_cls = isr_any_i ? isr_hi_i[VEC_W-1 -: CLS_W] : '0;
    tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
    irr_cls = irr_hi_i[VEC_W-1 -: CLS_W];
    ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {LO_W{1'b0}}};
    ppr_cls = ppr_o[VEC_W-1 -: CLS_W];
    // delivery compares class only
    irq_o   = sw_en_i && irr_any_i && !((ppr_o != '0) && (irr_cls <= ppr_cls));
    // acknowledge compares the full vector
    ack_ok_o = sw_en_i && irr_any_i && !((tpr_i != '0) && (irr_hi_i <= tpr_i));
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   set_valid_i,
  input  logic [$clog2(NUM_VEC)-1:0] set_vec_i,
  input  logic                   set_level_i,
  input  logic                   ack_i,
  output logic [$clog2(NUM_VEC)-1:0] ack_vec_o,
  input  logic                   eoi_i,
  input  logic                   tpr_we_i,
  input  logic [$clog2(NUM_VEC)-1:0] tpr_wdata_i,
  input  logic                   tpr_nib_we_i,
  input  logic [3:0]             tpr_nib_i,
  output logic [$clog2(NUM_VEC)-1:0] tpr_o,
  output logic [3:0]             tpr_nib_o,
  input  logic                   svr_we_i,
  input  logic [$clog2(NUM_VEC):0] svr_wdata_i,
  output logic [$clog2(NUM_VEC):0] svr_o,
  output logic [$clog2(NUM_VEC)-1:0] ppr_o,
  output logic                   irq_o,
  input  logic [1:0]             rd_sel_i,
  input  logic [$clog2(NUM_VEC/WORD_W)-1:0] rd_word_i,
  output logic [WORD_W-1:0]      rd_data_o
);
  import vpc_pkg::*;
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam int LO_W  = VEC_W - CLS_W;
  localparam logic [VEC_W:0] SVR_RST = {1'b0, {VEC_W{1'b1}}};

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q, irr_d, isr_d, tmr_d;
  logic [VEC_W-1:0]   tpr_q, irr_hi, isr_hi;
  logic [VEC_W:0]     svr_q;
  logic               irr_any, isr_any, ack_ok;

  vpc_hi_find #(.N(NUM_VEC), .W(WORD_W)) u_irr_find (
    .vec_i(irr_q), .any_o(irr_any), .idx_o(irr_hi));
  vpc_hi_find #(.N(NUM_VEC), .W(WORD_W)) u_isr_find (
    .vec_i(isr_q), .any_o(isr_any), .idx_o(isr_hi));

  vpc_prio_eval #(.VEC_W(VEC_W)) u_eval (
    .sw_en_i(svr_q[VEC_W]), .irr_any_i(irr_any), .irr_hi_i(irr_hi),
    .isr_any_i(isr_any), .isr_hi_i(isr_hi), .tpr_i(tpr_q),
    .ppr_o(ppr_o), .irq_o(irq_o), .ack_ok_o(ack_ok));

  // order within a cycle: eoi, then ack, then set
  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (eoi_i && isr_any) isr_d[isr_hi] = 1'b0;
    if (ack_i && ack_ok) begin
      irr_d[irr_hi] = 1'b0;
      isr_d[irr_hi] = 1'b1;
    end
    if (set_valid_i) begin
      irr_d[set_vec_i] = 1'b1;
      tmr_d[set_vec_i] = set_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
      tpr_q <= '0;
      svr_q <= SVR_RST;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
      if (tpr_we_i)          tpr_q <= tpr_wdata_i;
      else if (tpr_nib_we_i) tpr_q <= {tpr_nib_i, {LO_W{1'b0}}};
      if (svr_we_i)          svr_q <= svr_wdata_i;
    end
  end

  assign ack_vec_o = ack_ok ? irr_hi : svr_q[VEC_W-1:0];
  assign tpr_o     = tpr_q;
  assign tpr_nib_o = tpr_q[VEC_W-1 -: CLS_W];
  assign svr_o     = svr_q;

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      RD_PEND: rd_data_o = irr_q[int'(rd_word_i)*WORD_W +: WORD_W];
      RD_SERV: rd_data_o = isr_q[int'(rd_word_i)*WORD_W +: WORD_W];
      RD_TRIG: rd_data_o = tmr_q[int'(rd_word_i)*WORD_W +: WORD_W];
      default: rd_data_o = '0;
    endcase
  end

  a_r2_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_valid_i |=> irr_q[$past(set_vec_i)] && (tmr_q[$past(set_vec_i)] == $past(set_level_i)));
  a_r3_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> svr_q[VEC_W] && (irr_q != '0));
  a_r4_irq_above_ppr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ppr_o == '0) || (irr_hi > ppr_o));
  a_r5_ppr_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o >= tpr_q);
  a_r6_ack_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && ack_ok |=> isr_q[$past(irr_hi)]);
  a_r6_ack_leaves_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && ack_ok && !(set_valid_i && set_vec_i == irr_hi) |=> !irr_q[$past(irr_hi)]);
  a_r7_spurious_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !ack_ok && !set_valid_i |=> $stable(irr_q));
  a_r8_eoi_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i && !isr_any && !ack_i |=> isr_q == '0);
endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 100000;

  logic clk = 0, rst_ni = 0;
  logic set_valid, set_level, ack, eoi, tpr_we, tpr_nib_we, svr_we;
  logic [7:0] set_vec, tpr_wdata, ack_vec, tpr_v, ppr_v;
  logic [3:0] tpr_nib, tpr_nib_v;
  logic [8:0] svr_wdata, svr_v;
  logic irq;
  logic [1:0] rd_sel;
  logic [2:0] rd_word;
  logic [31:0] rd_data;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  bit [255:0] m_irr, m_isr, m_tmr;
  bit [7:0]   m_tpr;
  bit [8:0]   m_svr;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .set_valid_i(set_valid), .set_vec_i(set_vec), .set_level_i(set_level),
    .ack_i(ack), .ack_vec_o(ack_vec), .eoi_i(eoi),
    .tpr_we_i(tpr_we), .tpr_wdata_i(tpr_wdata),
    .tpr_nib_we_i(tpr_nib_we), .tpr_nib_i(tpr_nib),
    .tpr_o(tpr_v), .tpr_nib_o(tpr_nib_v),
    .svr_we_i(svr_we), .svr_wdata_i(svr_wdata), .svr_o(svr_v),
    .ppr_o(ppr_v), .irq_o(irq),
    .rd_sel_i(rd_sel), .rd_word_i(rd_word), .rd_data_o(rd_data));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int hi_of(bit [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int ih  = hi_of(m_isr);
    int cls = (ih < 0) ? 0 : (ih >> 4);
    if ((int'(m_tpr) >> 4) >= cls) return int'(m_tpr);
    return cls << 4;
  endfunction

  function automatic bit m_irq();
    int h = hi_of(m_irr);
    int p = m_ppr();
    if (!m_svr[8] || h < 0) return 0;
    if (p != 0 && (h >> 4) <= (p >> 4)) return 0;
    return 1;
  endfunction

  function automatic bit m_ack_ok();
    int h = hi_of(m_irr);
    return m_svr[8] && h >= 0 && !(m_tpr != 0 && h <= int'(m_tpr));
  endfunction

  function automatic int m_ackv();
    return m_ack_ok() ? hi_of(m_irr) : int'(m_svr[7:0]);
  endfunction

  function automatic logic [31:0] m_rd(int sel, int w);
    case (sel)
      0: return m_irr[w*32 +: 32];
      1: return m_isr[w*32 +: 32];
      2: return m_tmr[w*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic idle_in();
    set_valid = 0; set_vec = 0; set_level = 0; ack = 0; eoi = 0;
    tpr_we = 0; tpr_wdata = 0; tpr_nib_we = 0; tpr_nib = 0;
    svr_we = 0; svr_wdata = 0;
  endtask

  task automatic model_reset();
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0; m_svr = 9'h0FF;
  endtask

  task automatic model_update();
    int ih = hi_of(m_isr);
    int rh = hi_of(m_irr);
    bit ok = m_ack_ok();
    if (eoi && ih >= 0) m_isr[ih] = 0;
    if (ack && ok) begin m_irr[rh] = 0; m_isr[rh] = 1; end
    if (set_valid) begin m_irr[set_vec] = 1; m_tmr[set_vec] = set_level; end
    if (tpr_we) m_tpr = tpr_wdata;
    else if (tpr_nib_we) m_tpr = {tpr_nib, 4'h0};
    if (svr_we) m_svr = svr_wdata;
  endtask

  // called at negedge with inputs set; compares, clocks, returns at next negedge
  task automatic step();
    rd_sel  = 2'(cyc % 4);
    rd_word = 3'((cyc / 4) % 8);
    #1;
    chk("R3_R4 irq", 32'(irq), 32'(m_irq()));
    chk("R5 ppr", 32'(ppr_v), 32'(m_ppr()));
    chk("R6_R7 ack_vec", 32'(ack_vec), 32'(m_ackv()));
    chk("R10 tpr", 32'(tpr_v), 32'(m_tpr));
    chk("R10 tpr_nib", 32'(tpr_nib_v), 32'(m_tpr[7:4]));
    chk("R9 svr", 32'(svr_v), 32'(m_svr));
    chk("R13 readback", rd_data, m_rd(int'(rd_sel), int'(rd_word)));
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle_in();
  endtask

  task automatic rd(int sel, int w, output logic [31:0] d);
    rd_sel = 2'(sel); rd_word = 3'(w);
    #1 d = rd_data;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, MAX_CYC);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle_in();
    rd_sel = 0; rd_word = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // reset state
    chk("R12 tpr after reset", 32'(tpr_v), 0);
    chk("R12 ppr after reset", 32'(ppr_v), 0);
    chk("R9 svr reset value", 32'(svr_v), 32'h0FF);
    chk("R3 irq after reset", 32'(irq), 0);
    for (int s = 0; s < 3; s++)
      for (int w = 0; w < 8; w++) begin
        rd(s, w, d);
        chk("R12 vectors clear", d, 0);
      end

    // disabled block
    set_valid = 1; set_vec = 8'h45; set_level = 0; step();
    chk("R3 disabled no irq", 32'(irq), 0);
    chk("R7 disabled ack spurious", 32'(ack_vec), 32'hFF);
    ack = 1; step();
    rd(0, 2, d);
    chk("R7 pending kept", 32'(d[5]), 1);

    // enable with spurious 0x3F
    svr_we = 1; svr_wdata = 9'h13F; step();
    chk("R9 svr stored", 32'(svr_v), 32'h13F);
    chk("R3 irq enabled", 32'(irq), 1);

    set_valid = 1; set_vec = 8'hA2; set_level = 1; step();
    set_valid = 1; set_vec = 8'h30; set_level = 0; step();
    rd(2, 5, d); chk("R2 level trigger bit", 32'(d[2]), 1);
    rd(0, 5, d); chk("R2 pending bit", 32'(d[2]), 1);
    rd(2, 1, d); chk("R2 edge trigger bit", 32'(d[16]), 0);
    chk("R1 highest acked", 32'(ack_vec), 32'hA2);
    ack = 1; step();
    rd(1, 5, d); chk("R6 moved to service", 32'(d[2]), 1);
    rd(0, 5, d); chk("R6 left pending", 32'(d[2]), 0);
    chk("R5 ppr from service", 32'(ppr_v), 32'hA0);
    chk("R4 class blocked", 32'(irq), 0);
    eoi = 1; step();
    rd(1, 5, d); chk("R8 eoi clears", d, 0);
    chk("R4 irq back", 32'(irq), 1);

    // task priority blocks
    tpr_we = 1; tpr_wdata = 8'h50; step();
    chk("R7 below tpr spurious", 32'(ack_vec), 32'h3F);
    chk("R5 ppr from tpr", 32'(ppr_v), 32'h50);
    chk("R4 tpr blocks irq", 32'(irq), 0);
    ack = 1; step();
    rd(0, 2, d); chk("R7 spurious keeps pending", 32'(d[5]), 1);

    // class port
    tpr_nib_we = 1; tpr_nib = 4'h3; step();
    chk("R10 class write", 32'(tpr_v), 32'h30);
    chk("R10 class readback", 32'(tpr_nib_v), 3);
    tpr_we = 1; tpr_wdata = 8'h27; tpr_nib_we = 1; tpr_nib = 4'h9; step();
    chk("R10 full write wins", 32'(tpr_v), 32'h27);
    tpr_nib_we = 1; tpr_nib = 4'h3; step();
    chk("R6 above tpr acked", 32'(ack_vec), 32'h45);
    ack = 1; step();
    chk("R5 service class over tpr", 32'(ppr_v), 32'h40);
    chk("R4 lower class blocked", 32'(irq), 0);

    // set and ack same vector
    tpr_we = 1; tpr_wdata = 8'h00; step();
    ack = 1; set_valid = 1; set_vec = 8'h30; step();
    rd(1, 1, d); chk("R11 in service", 32'(d[16]), 1);
    rd(0, 1, d); chk("R11 pending again", 32'(d[16]), 1);

    // eoi sequence
    eoi = 1; step();
    chk("R8 next in service class", 32'(ppr_v), 32'h30);
    eoi = 1; step();
    eoi = 1; step();
    for (int w = 0; w < 8; w++) begin
      rd(1, w, d); chk("R8 empty eoi no effect", d, 0);
    end
    rd(0, 1, d); chk("R8 eoi leaves pending", 32'(d[16]), 1);

    // reset mid-run
    rst_ni = 0; model_reset(); #1;
    rd(0, 1, d); chk("R12 pending cleared", d, 0);
    chk("R12 tpr cleared", 32'(tpr_v), 0);
    chk("R9 svr reset again", 32'(svr_v), 32'h0FF);
    @(negedge clk); rst_ni = 1; @(negedge clk);

    svr_we = 1; svr_wdata = 9'h1F0; step();
    for (int i = 0; i < 3000; i++) begin
      set_valid = ($urandom % 10) < 4;
      set_vec   = 8'($urandom);
      set_level = 1'($urandom);
      ack       = ($urandom % 4) == 0;
      eoi       = ($urandom % 5) == 0;
      tpr_we    = ($urandom % 20) == 0;
      tpr_wdata = 8'($urandom);
      tpr_nib_we = ($urandom % 20) == 0;
      tpr_nib   = 4'($urandom);
      svr_we    = ($urandom % 40) == 0;
      svr_wdata = {1'(($urandom % 4) != 0), 8'($urandom)};
      step();
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule